// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a 16-bit segment value and a 16-bit unsigned offset into a 20-bit physical byte address. The segment is shifted left by four bit positions, with zeros filling the low nibble, and the offset is added to it. The result addresses a 1 MB byte space. Four segment registers are kept inside the unit: code, data, stack and extra. They are loaded through a small write port. Each request names only the kind of access. The unit then picks the segment by that kind. Instruction fetches use the code segment. Accesses made through the stack pointer or the frame (base) pointer use the stack segment. All other data accesses use the data segment.

Memory sits behind a byte-wide synchronous port. Read data returns one cycle after the enable. A 16-bit access becomes two back-to-back byte transactions, low byte first at the computed address and high byte at the next address. While the transfer runs, `busy` stays high. A one-cycle `done` pulse then ends it, and on reads it comes with the assembled value. Requests are taken only while the unit is idle.

Top module: `segaddr_unit`

## Requirements
- R1: After reset, busy, done, mem_en and rd_data are all zero, and all four segment registers read as zero, so a fetch at offset 0x1234 goes to physical address 0x01234.
- R2: The physical address equals (segment << 4) + offset, with the offset taken as unsigned. Segment 0x027A with offset 0x0017 gives 0x027B7, and segment 0x0000 with offset 0xFFFF gives 0x0FFFF.
- R3: The segment comes from req_kind: 0 (fetch) uses code, 1 (stack pointer) and 2 (frame pointer) use stack, 3 (data) uses data. seg_sel selects 0 code, 1 data, 2 stack, 3 extra.
- R4: The sum is cut to 20 bits. Segment 0xFFFF with offset 0x0010 gives 0x00000. The second byte of a word access at 0xFFFFF goes to 0x00000.
- R5: A word write (req_word=1, req_wr=1) issues exactly two memory writes on consecutive cycles. The first writes req_wdata[7:0] at the computed address and the second writes req_wdata[15:8] at that address plus one.
- R6: A word read returns, on rd_data while done is high, the byte from the computed address in bits 7:0 and the byte from the next address in bits 15:8.
- R7: A byte access (req_word=0) makes a single memory transaction. A byte write stores req_wdata[7:0], and a byte read returns the byte zero-extended in rd_data.
- R8: Counting from the clock edge that accepts a request, busy is high for 3 cycles on a word access and 2 cycles on a byte access. done is then high for exactly one cycle, with busy low.
- R9: Loading one segment register leaves the others unchanged. In particular, a load of the extra segment does not move fetch or data addresses.
- R10: While busy is high, req_valid is ignored and no further memory transactions are started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register load strobe |
| seg_sel | input | 2 | Segment register to load (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | Segment value to load |
| req_valid | input | 1 | Access request, taken when busy is low |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack pointer, 2 frame pointer, 3 data |
| req_off | input | 16 | Unsigned offset within the segment |
| req_wr | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 for a 16-bit access, 0 for one byte |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid while done is high |
| mem_en | output | 1 | Memory transaction enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after mem_en |

## Verification
The bench targets the places where address arithmetic tends to break. It checks wrap past 0xFFFFF on the sum and on the second byte of a word. A design that kept a 21st bit or did not truncate the +1 would put bytes above the 1 MB space. It checks offsets with the top bit set, because a sign-extending adder would point 0xFFFF below the segment base. It checks byte order on stores and reads, since a swapped split writes 0x35 where 0xF3 belongs. It checks the stack-versus-data choice for each access kind, and it checks that requests arriving while busy are dropped. A design that re-armed during a transfer would issue a third byte transaction.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_STACK = 2'd1,
      ACC_FRAME = 2'd2,
      ACC_DATA  = 2'd3
   } acc_kind_e;

   localparam int unsigned NSEG      = 4;
   localparam int unsigned SEL_W     = 2;
   localparam logic [1:0]  SEG_CODE  = 2'd0;
   localparam logic [1:0]  SEG_DATA  = 2'd1;
   localparam logic [1:0]  SEG_STACK = 2'd2;
   localparam logic [1:0]  SEG_EXTRA = 2'd3;

   function automatic logic [1:0] default_seg(acc_kind_e kind);
      logic [1:0] sel;
      case (kind)
         ACC_FETCH: sel = SEG_CODE;
         ACC_STACK: sel = SEG_STACK;
         ACC_FRAME: sel = SEG_STACK;
         default:   sel = SEG_DATA;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/segaddr_segfile.sv
module segaddr_segfile #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned NREG  = 4,
   parameter int unsigned SW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SW-1:0]    wsel,
   input  logic [SEG_W-1:0] wdata,
   input  logic [SW-1:0]    rsel,
   output logic [SEG_W-1:0] rdata
);

   if (NREG > (1 << SW)) begin : g_bad_sel
      $error("segaddr_segfile: select too narrow for register count");
   end
   if (SEG_W == 0) begin : g_bad_w
      $error("segaddr_segfile: zero segment width");
   end

   logic [SEG_W-1:0] seg_q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seg_q[i] <= '0;
         end else if (we && (wsel == SW'(i))) begin
            seg_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NREG; k++) begin
         if (rsel == SW'(k)) rdata = seg_q[k];
      end
   end

endmodule

// File: rtl/segaddr_phys.sv
module segaddr_phys #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned SHIFT = 4,
   parameter int unsigned PA_W  = 20
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  phys
);

   localparam int unsigned BASE_W = SEG_W + SHIFT;
   localparam int unsigned SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

   if (SHIFT == 0) begin : g_bad_shift
      $error("segaddr_phys: shift must be at least one");
   end
   if (PA_W < OFF_W) begin : g_bad_pa_lo
      $error("segaddr_phys: physical width below offset width");
   end
   if (PA_W >= SUM_W) begin : g_bad_pa_hi
      $error("segaddr_phys: physical width wider than the sum");
   end

   logic [SUM_W-1:0] base_ext;
   logic [SUM_W-1:0] off_ext;
   logic [SUM_W-1:0] sum;

   assign base_ext = {{(SUM_W-BASE_W){1'b0}}, seg, {SHIFT{1'b0}}};
   assign off_ext  = {{(SUM_W-OFF_W){1'b0}}, off};
   assign sum      = base_ext + off_ext;
   assign phys     = sum[PA_W-1:0];

endmodule

// File: rtl/segaddr_xfer.sv
module segaddr_xfer #(
   parameter int unsigned PA_W   = 20,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PA_W-1:0]   base,
   input  logic              word,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_en,
   output logic              mem_we,
   output logic [PA_W-1:0]   mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);

   localparam int unsigned LANES = DATA_W / BYTE_W;
   localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1;

   if ((DATA_W % BYTE_W) != 0) begin : g_bad_lanes
      $error("segaddr_xfer: data width not a whole number of bytes");
   end
   if (PA_W <= LW) begin : g_bad_pa
      $error("segaddr_xfer: address too narrow");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_TAIL} st_e;

   st_e               state;
   logic [PA_W-1:0]   base_q;
   logic [LW-1:0]     lane_q;
   logic [LW-1:0]     last_q;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              done_q;
   logic [DATA_W-1:0] rd_q;
   logic [BYTE_W-1:0] buf_q    [LANES];
   logic [BYTE_W-1:0] lane_asm [LANES];
   logic [DATA_W-1:0] asm_flat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_q  <= '0;
         lane_q  <= '0;
         last_q  <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         done_q  <= 1'b0;
         rd_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_ISSUE;
                  base_q  <= base;
                  lane_q  <= '0;
                  last_q  <= word ? LW'(LANES - 1) : '0;
                  wr_q    <= wr;
                  wdata_q <= wdata;
               end
            end
            ST_ISSUE: begin
               if (lane_q == last_q) state <= ST_TAIL;
               else                  lane_q <= lane_q + 1'b1;
            end
            ST_TAIL: begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
               if (!wr_q) rd_q <= asm_flat;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i < LANES - 1) begin : g_cap
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               buf_q[i] <= '0;
            end else if ((state == ST_ISSUE) && (lane_q != '0) &&
                         ((lane_q - 1'b1) == LW'(i))) begin
               buf_q[i] <= mem_rdata;
            end
         end
      end else begin : g_top
         assign buf_q[i] = '0;
      end

      always_comb begin
         if (LW'(i) == last_q)     lane_asm[i] = mem_rdata;
         else if (LW'(i) > last_q) lane_asm[i] = '0;
         else                      lane_asm[i] = buf_q[i];
      end

      assign asm_flat[i*BYTE_W +: BYTE_W] = lane_asm[i];
   end

   assign busy      = (state != ST_IDLE);
   assign done      = done_q;
   assign rd_data   = rd_q;
   assign mem_en    = (state == ST_ISSUE);
   assign mem_we    = (state == ST_ISSUE) && wr_q;
   assign mem_addr  = base_q + {{(PA_W-LW){1'b0}}, lane_q};
   assign mem_wdata = wdata_q[int'(lane_q)*BYTE_W +: BYTE_W];

endmodule

// File: rtl/segaddr_unit.sv
module segaddr_unit
   import segaddr_pkg::*;
#(
   parameter int unsigned SEG_W  = 16,
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned SHIFT  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned PA_W  = SEG_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_we,
   input  logic [1:0]        seg_sel,
   input  logic [SEG_W-1:0]  seg_wdata,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              req_wr,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_en,
   output logic              mem_we,
   output logic [PA_W-1:0]   mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);

   logic [SEL_W-1:0] rd_sel;
   logic [SEG_W-1:0] seg_val;
   logic [PA_W-1:0]  phys;

   assign rd_sel = default_seg(acc_kind_e'(req_kind));

   segaddr_segfile #(
      .SEG_W (SEG_W),
      .NREG  (NSEG),
      .SW    (SEL_W)
   ) u_segs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (seg_we),
      .wsel  (seg_sel),
      .wdata (seg_wdata),
      .rsel  (rd_sel),
      .rdata (seg_val)
   );

   segaddr_phys #(
      .SEG_W (SEG_W),
      .OFF_W (OFF_W),
      .SHIFT (SHIFT),
      .PA_W  (PA_W)
   ) u_phys (
      .seg  (seg_val),
      .off  (req_off),
      .phys (phys)
   );

   segaddr_xfer #(
      .PA_W   (PA_W),
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_valid),
      .base      (phys),
      .word      (req_word),
      .wr        (req_wr),
      .wdata     (req_wdata),
      .busy      (busy),
      .done      (done),
      .rd_data   (rd_data),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

endmodule

// File: rtl/segaddr_unit_chk.sv
module segaddr_unit_chk #(
   parameter int unsigned PA_W = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            busy,
   input logic            done,
   input logic            mem_en,
   input logic            mem_we,
   input logic [PA_W-1:0] mem_addr
);

   // R8: an accepted request raises busy on the next cycle
   a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   // R8: done lasts one cycle
   a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: done follows the end of busy
   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R4 / R5: back-to-back byte transactions step the address by one, wrapping
   a_r5_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   // R10: no memory activity while idle
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);

   // R7: a write strobe never appears without an enable
   a_r7_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);

endmodule

bind segaddr_unit segaddr_unit_chk #(.PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/segaddr_unit_tb.sv
module segaddr_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_we = 1'b0;
   logic [1:0]  seg_sel = '0;
   logic [15:0] seg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_off = '0;
   logic        req_wr = 1'b0;
   logic        req_word = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, mem_en, mem_we;
   logic [15:0] rd_data;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   logic [7:0] mem_aa [int];
   int         op_addr [$];
   logic       op_we   [$];
   logic [7:0] op_data [$];

   always #4 clk = ~clk;

   segaddr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_sel(seg_sel),
      .seg_wdata(seg_wdata), .req_valid(req_valid), .req_kind(req_kind),
      .req_off(req_off), .req_wr(req_wr), .req_word(req_word),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] peek(int a);
      if (mem_aa.exists(a)) return mem_aa[a];
      return 8'(a) ^ {4'(a >> 16), 4'(a >> 8)};
   endfunction

   always @(posedge clk) begin
      if (mem_en) begin
         op_addr.push_back(int'(mem_addr));
         op_we.push_back(mem_we);
         op_data.push_back(mem_wdata);
         if (mem_we) mem_aa[int'(mem_addr)] = mem_wdata;
         else        mem_rdata <= peek(int'(mem_addr));
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_seg(logic [1:0] sel, logic [15:0] val);
      @(negedge clk);
      seg_we = 1'b1; seg_sel = sel; seg_wdata = val;
      @(negedge clk);
      seg_we = 1'b0;
   endtask

   task automatic access(input logic [1:0] kind, input logic [15:0] off,
                         input logic wr, input logic word, input logic [15:0] wd,
                         output logic [15:0] rd, output int busy_cyc);
      int guard;
      op_addr.delete(); op_we.delete(); op_data.delete();
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_off = off;
      req_wr = wr; req_word = word; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      busy_cyc = 0;
      guard = 0;
      while (!done && guard < 50) begin
         if (busy) busy_cyc++;
         @(negedge clk);
         guard++;
      end
      rd = rd_data;
      if (guard >= 50) check("access timeout", 32'd0, 32'd1);
   endtask

   task automatic t_reset();
      logic [15:0] rd; int bc;
      check("R1 busy", 32'(busy), 32'd0);
      check("R1 done", 32'(done), 32'd0);
      check("R1 mem_en", 32'(mem_en), 32'd0);
      check("R1 rd_data", 32'(rd_data), 32'd0);
      access(2'd0, 16'h1234, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R1 zero code segment", 32'(op_addr[0]), 32'h01234);
   endtask

   task automatic t_formula();
      logic [15:0] rd; int bc;
      load_seg(2'd1, 16'h027A);
      access(2'd3, 16'h0017, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R2 027A:0017", 32'(op_addr[0]), 32'h027B7);
      load_seg(2'd1, 16'h0000);
      access(2'd3, 16'hFFFF, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R2 unsigned offset", 32'(op_addr[0]), 32'h0FFFF);
      load_seg(2'd1, 16'h1234);
      access(2'd3, 16'h8000, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R2 1234:8000", 32'(op_addr[0]), 32'h1A340);
   endtask

   task automatic t_default_seg();
      logic [15:0] rd; int bc;
      load_seg(2'd0, 16'h1000);
      load_seg(2'd1, 16'h2000);
      load_seg(2'd2, 16'h3000);
      load_seg(2'd3, 16'h4000);
      access(2'd0, 16'h0005, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R3 fetch uses code", 32'(op_addr[0]), 32'h10005);
      access(2'd1, 16'h0005, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R3 stack ptr uses stack", 32'(op_addr[0]), 32'h30005);
      access(2'd2, 16'h0005, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R3 frame ptr uses stack", 32'(op_addr[0]), 32'h30005);
      access(2'd3, 16'h0005, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R3 data uses data", 32'(op_addr[0]), 32'h20005);
   endtask

   task automatic t_seg_isolation();
      logic [15:0] rd; int bc;
      load_seg(2'd3, 16'hABCD);
      access(2'd3, 16'h0005, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R9 extra load keeps data", 32'(op_addr[0]), 32'h20005);
      access(2'd0, 16'h0005, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R9 extra load keeps code", 32'(op_addr[0]), 32'h10005);
      load_seg(2'd2, 16'h0777);
      access(2'd3, 16'h0005, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R9 stack load keeps data", 32'(op_addr[0]), 32'h20005);
   endtask

   task automatic t_wrap();
      logic [15:0] rd; int bc;
      load_seg(2'd1, 16'hFFFF);
      access(2'd3, 16'h0010, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R4 FFFF:0010 wraps", 32'(op_addr[0]), 32'h00000);
      load_seg(2'd1, 16'hF000);
      access(2'd3, 16'hFFFF, 1'b0, 1'b1, 16'h0, rd, bc);
      check("R4 top byte", 32'(op_addr[0]), 32'hFFFFF);
      check("R4 second byte wraps", 32'(op_addr[1]), 32'h00000);
      check("R6 wrapped word read", 32'(rd), 32'({peek(0), peek(32'hFFFFF)}));
   endtask

   task automatic t_store();
      logic [15:0] rd; int bc;
      load_seg(2'd1, 16'h3146);
      access(2'd3, 16'h1500, 1'b1, 1'b1, 16'h35F3, rd, bc);
      check("R5 op count", 32'(op_addr.size()), 32'd2);
      check("R5 low addr", 32'(op_addr[0]), 32'h32960);
      check("R5 low data", 32'(op_data[0]), 32'hF3);
      check("R5 low we", 32'(op_we[0]), 32'd1);
      check("R5 high addr", 32'(op_addr[1]), 32'h32961);
      check("R5 high data", 32'(op_data[1]), 32'h35);
      access(2'd3, 16'h1500, 1'b0, 1'b1, 16'h0, rd, bc);
      check("R6 word read back", 32'(rd), 32'h35F3);
      access(2'd3, 16'h1501, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R7 byte read zero-ext", 32'(rd), 32'h0035);
      access(2'd3, 16'h1600, 1'b1, 1'b0, 16'hBEEF, rd, bc);
      check("R7 byte write single op", 32'(op_addr.size()), 32'd1);
      check("R7 byte write data", 32'(op_data[0]), 32'hEF);
      access(2'd3, 16'h1601, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R7 neighbour untouched", 32'(rd), 32'(peek(32'h32A61)));
   endtask

   task automatic t_timing();
      logic [15:0] rd; int bc;
      access(2'd3, 16'h0040, 1'b0, 1'b1, 16'h0, rd, bc);
      check("R8 word busy cycles", 32'(bc), 32'd3);
      check("R8 busy low at done", 32'(busy), 32'd0);
      @(negedge clk);
      check("R8 done one cycle", 32'(done), 32'd0);
      access(2'd3, 16'h0040, 1'b0, 1'b0, 16'h0, rd, bc);
      check("R8 byte busy cycles", 32'(bc), 32'd2);
   endtask

   task automatic t_busy_ignore();
      int guard;
      load_seg(2'd1, 16'h0500);
      op_addr.delete(); op_we.delete(); op_data.delete();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd3; req_off = 16'h0010;
      req_wr = 1'b0; req_word = 1'b1;
      @(negedge clk);
      req_off = 16'h0200; req_word = 1'b0;
      guard = 0;
      while (busy && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 only two ops", 32'(op_addr.size()), 32'd2);
      check("R10 first op addr", 32'(op_addr[0]), 32'h05010);
      check("R10 second op addr", 32'(op_addr[1]), 32'h05011);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_during: begin
         check("R1 busy in reset", 32'(busy), 32'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_formula();
      t_default_seg();
      t_seg_isolation();
      t_wrap();
      t_store();
      t_timing();
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule